// File: doc/BRIEF.md
# Clock monitor with backup failover

This block supervises a chip's clock tree from the side of a trusted backup reference clock. It counts rising edges of the monitored bus clock over a fixed window of reference cycles. Each count is compared against a programmable upper and lower bound. An excessive count latches an over-frequency flag and a short count latches an under-frequency flag. Either flag raises a common interrupt, and software may route that interrupt on as a reset request. The upper bound is normally set just above the count that a 100 MHz bus clock gives, so an over-clocking attempt is caught within one window.

In parallel, a source-selection guard watches the lock indicators of the system PLL and the peripheral PLL. The requested clock-select code passes to the output unchanged as long as nothing is wrong. Suppose the PLL code (01) is requested and either PLL reports loss of lock. The effective code is then forced to the backup code (00) and held there. It is released only after software issues a clear while both PLLs are locked again. The analog PLLs and the glitch-free clock multiplexer that consumes the select code are outside this block.

The block uses three state machines. The meter has state MS_PRIME, which discards the first window after reset because the synchronizer still holds reset values, and moves to MS_MEASURE at the end of that window. MS_MEASURE then reports one count per window. The judge moves from JD_CLEAN to JD_FAULT when either frequency flag becomes set, and moves back to JD_CLEAN when a clear leaves both flags low. The guard moves from SW_FOLLOW to SW_FAILOVER on a PLL fault while code 01 is requested. It moves from SW_FAILOVER back to SW_FOLLOW on a clear while both locks are present.

Top module: `clkguard_top`

## Requirements
- R1: After reset, sel_o equals sel_req_i, and bkp_active_o, sys_fault_o, per_fault_o, over_o, under_o, irq_o and rst_req_o are all 0.
- R2: In the follow state, sel_o equals sel_req_i for every code (00 backup, 01 PLL, 10 and 11 other sources) while no PLL fault exists.
- R3: With sel_req_i = 01, a fall of sys_lock_i leaves sel_o at 01 after the second rising edge of clk_ref, and sets sel_o = 00, bkp_active_o = 1 and sys_fault_o = 1 after the third edge, with the default two-stage synchronizer.
- R4: With sel_req_i = 01, a fall of per_lock_i forces sel_o = 00 and bkp_active_o = 1, and sets per_fault_o while sys_fault_o stays 0.
- R5: Loss of lock while sel_req_i is not 01 causes no switchover and sets no fault flag.
- R6: The switchover is sticky. It ignores returning lock and any new sel_req_i code. A clear (err_clr_i) while either lock is low keeps the backup code. A clear with both locks present returns to following sel_req_i.
- R7: The count of clk_mon rising edges over WIN_CYC clk_ref cycles sets over_o when it exceeds thr_hi_i.
- R8: A count below thr_lo_i sets under_o. A count within the bounds sets neither flag.
- R9: irq_o is high while over_o or under_o is set. Both flags stay set after the clock returns to range, until err_clr_i.
- R10: rst_req_o follows irq_o when rst_route_i is 1 and stays 0 when rst_route_i is 0.
- R11: sys_lock_o and per_lock_o report the lock inputs after synchronization into the clk_ref domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Trusted backup reference clock; all control logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_mon | input | 1 | Monitored bus clock |
| sys_lock_i | input | 1 | System PLL lock indicator (asynchronous) |
| per_lock_i | input | 1 | Peripheral PLL lock indicator (asynchronous) |
| sel_req_i | input | 2 | Clock-select code requested by software |
| thr_hi_i | input | CNT_W | Upper bound on edges per window |
| thr_lo_i | input | CNT_W | Lower bound on edges per window |
| err_clr_i | input | 1 | One-cycle clear of frequency and PLL fault state |
| rst_route_i | input | 1 | Routes the interrupt to a reset request |
| sel_o | output | 2 | Effective clock-select code |
| bkp_active_o | output | 1 | Backup clock forced by the guard |
| sys_fault_o | output | 1 | System PLL lock-loss fault latched |
| per_fault_o | output | 1 | Peripheral PLL lock-loss fault latched |
| sys_lock_o | output | 1 | Synchronized system PLL lock status |
| per_lock_o | output | 1 | Synchronized peripheral PLL lock status |
| over_o | output | 1 | Over-frequency flag |
| under_o | output | 1 | Under-frequency flag |
| irq_o | output | 1 | Clock-fault interrupt |
| rst_req_o | output | 1 | Reset request |

## Verification
A lock loss and a frequency violation can both be pending at the same time, with the guard entering SW_FAILOVER while the judge enters JD_FAULT. The bench provokes this by speeding up clk_mon and dropping the system PLL lock on the same reference edge. It then expects the backup code, the system fault, the over-frequency flag and the interrupt all at once. After both causes are removed, a single clear must release both machines together: the select code returns to 01 and the interrupt drops, and neither side may be left behind.

// File: rtl/clkguard_pkg.sv
package clkguard_pkg;

    localparam logic [1:0] SEL_BACKUP = 2'b00;
    localparam logic [1:0] SEL_PLL    = 2'b01;

    typedef enum logic {
        MS_PRIME,
        MS_MEASURE
    } meter_state_e;

    typedef enum logic {
        JD_CLEAN,
        JD_FAULT
    } judge_state_e;

    typedef enum logic {
        SW_FOLLOW,
        SW_FAILOVER
    } switch_state_e;

endpackage

// File: rtl/clkguard_sync.sv
module clkguard_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/clkguard_meter.sv
module clkguard_meter
    import clkguard_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int WIN_CYC     = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_mon,
    input  logic             clk_ref,
    input  logic             rst_n,
    output logic             meas_vld_o,
    output logic [CNT_W-1:0] meas_cnt_o
);

    localparam int WIN_W = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);

    function automatic logic [CNT_W-1:0] gray_to_bin(input logic [CNT_W-1:0] g);
        logic [CNT_W-1:0] b;
        b[CNT_W-1] = g[CNT_W-1];
        for (int i = CNT_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // monitored-clock domain: free-running edge counter, published in Gray code
    logic [CNT_W-1:0] edge_bin_q;
    logic [CNT_W-1:0] edge_gray_q;
    logic [CNT_W-1:0] edge_bin_nx;

    assign edge_bin_nx = edge_bin_q + CNT_W'(1);

    always_ff @(posedge clk_mon or negedge rst_n) begin
        if (!rst_n) begin
            edge_bin_q  <= '0;
            edge_gray_q <= '0;
        end else begin
            edge_bin_q  <= edge_bin_nx;
            edge_gray_q <= edge_bin_nx ^ (edge_bin_nx >> 1);
        end
    end

    // reference domain
    logic [CNT_W-1:0] gray_ref;
    logic [CNT_W-1:0] cur_bin;

    clkguard_sync #(
        .W      (CNT_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL('0)
    ) u_gray_sync (
        .clk  (clk_ref),
        .rst_n(rst_n),
        .d_i  (edge_gray_q),
        .q_o  (gray_ref)
    );

    assign cur_bin = gray_to_bin(gray_ref);

    meter_state_e     state_q, state_d;
    logic [WIN_W-1:0] win_q;
    logic [CNT_W-1:0] snap_q;
    logic             win_end;

    assign win_end = (win_q == WIN_LAST);

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) state_q <= MS_PRIME;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_PRIME:   if (win_end) state_d = MS_MEASURE;
            MS_MEASURE: state_d = MS_MEASURE;
            default:    state_d = MS_PRIME;
        endcase
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            win_q      <= '0;
            snap_q     <= '0;
            meas_vld_o <= 1'b0;
            meas_cnt_o <= '0;
        end else begin
            win_q      <= win_end ? '0 : win_q + WIN_W'(1);
            meas_vld_o <= win_end && (state_q == MS_MEASURE);
            if (win_end) begin
                snap_q     <= cur_bin;
                meas_cnt_o <= cur_bin - snap_q;
            end
        end
    end

endmodule

// File: rtl/clkguard_judge.sv
module clkguard_judge
    import clkguard_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas_vld_i,
    input  logic [CNT_W-1:0] meas_cnt_i,
    input  logic [CNT_W-1:0] thr_hi_i,
    input  logic [CNT_W-1:0] thr_lo_i,
    input  logic             clr_i,
    output logic             over_o,
    output logic             under_o,
    output logic             irq_o
);

    judge_state_e state_q, state_d;
    logic over_q, under_q, over_d, under_d;

    // a fresh violation in the clear cycle wins over the clear
    always_comb begin
        over_d  = (over_q  & ~clr_i) | (meas_vld_i & (meas_cnt_i > thr_hi_i));
        under_d = (under_q & ~clr_i) | (meas_vld_i & (meas_cnt_i < thr_lo_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= JD_CLEAN;
            over_q  <= 1'b0;
            under_q <= 1'b0;
        end else begin
            state_q <= state_d;
            over_q  <= over_d;
            under_q <= under_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            JD_CLEAN: if (over_d || under_d)    state_d = JD_FAULT;
            JD_FAULT: if (!(over_d || under_d)) state_d = JD_CLEAN;
            default:  state_d = JD_CLEAN;
        endcase
    end

    always_comb begin
        over_o  = over_q;
        under_o = under_q;
        irq_o   = (state_q == JD_FAULT);
    end

endmodule

// File: rtl/clkguard_switch.sv
module clkguard_switch
    import clkguard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel_req_i,
    input  logic       sys_lock_i,
    input  logic       per_lock_i,
    input  logic       clr_i,
    output logic [1:0] sel_o,
    output logic       bkp_active_o,
    output logic       sys_fault_o,
    output logic       per_fault_o
);

    switch_state_e state_q, state_d;
    logic pll_sel, locks_ok;
    logic sys_flt_q, per_flt_q;

    assign pll_sel  = (sel_req_i == SEL_PLL);
    assign locks_ok = sys_lock_i & per_lock_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= SW_FOLLOW;
            sys_flt_q <= 1'b0;
            per_flt_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            sys_flt_q <= (sys_flt_q & ~clr_i) | (pll_sel & ~sys_lock_i);
            per_flt_q <= (per_flt_q & ~clr_i) | (pll_sel & ~per_lock_i);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_FOLLOW:   if (pll_sel && !locks_ok) state_d = SW_FAILOVER;
            SW_FAILOVER: if (clr_i && locks_ok)    state_d = SW_FOLLOW;
            default:     state_d = SW_FOLLOW;
        endcase
    end

    always_comb begin
        sel_o        = (state_q == SW_FOLLOW) ? sel_req_i : SEL_BACKUP;
        bkp_active_o = (state_q == SW_FAILOVER);
        sys_fault_o  = sys_flt_q;
        per_fault_o  = per_flt_q;
    end

endmodule

// File: rtl/clkguard_top.sv
module clkguard_top
    import clkguard_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int WIN_CYC     = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             clk_mon,
    input  logic             sys_lock_i,
    input  logic             per_lock_i,
    input  logic [1:0]       sel_req_i,
    input  logic [CNT_W-1:0] thr_hi_i,
    input  logic [CNT_W-1:0] thr_lo_i,
    input  logic             err_clr_i,
    input  logic             rst_route_i,
    output logic [1:0]       sel_o,
    output logic             bkp_active_o,
    output logic             sys_fault_o,
    output logic             per_fault_o,
    output logic             sys_lock_o,
    output logic             per_lock_o,
    output logic             over_o,
    output logic             under_o,
    output logic             irq_o,
    output logic             rst_req_o
);

    logic [1:0]       lock_sync;
    logic             meas_vld;
    logic [CNT_W-1:0] meas_cnt;

    // locks are presumed present out of reset so no false failover occurs
    clkguard_sync #(
        .W      (2),
        .STAGES (SYNC_STAGES),
        .RST_VAL(2'b11)
    ) u_lock_sync (
        .clk  (clk_ref),
        .rst_n(rst_n),
        .d_i  ({per_lock_i, sys_lock_i}),
        .q_o  (lock_sync)
    );

    clkguard_meter #(
        .CNT_W      (CNT_W),
        .WIN_CYC    (WIN_CYC),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_meter (
        .clk_mon   (clk_mon),
        .clk_ref   (clk_ref),
        .rst_n     (rst_n),
        .meas_vld_o(meas_vld),
        .meas_cnt_o(meas_cnt)
    );

    clkguard_judge #(
        .CNT_W(CNT_W)
    ) u_judge (
        .clk       (clk_ref),
        .rst_n     (rst_n),
        .meas_vld_i(meas_vld),
        .meas_cnt_i(meas_cnt),
        .thr_hi_i  (thr_hi_i),
        .thr_lo_i  (thr_lo_i),
        .clr_i     (err_clr_i),
        .over_o    (over_o),
        .under_o   (under_o),
        .irq_o     (irq_o)
    );

    clkguard_switch u_switch (
        .clk         (clk_ref),
        .rst_n       (rst_n),
        .sel_req_i   (sel_req_i),
        .sys_lock_i  (lock_sync[0]),
        .per_lock_i  (lock_sync[1]),
        .clr_i       (err_clr_i),
        .sel_o       (sel_o),
        .bkp_active_o(bkp_active_o),
        .sys_fault_o (sys_fault_o),
        .per_fault_o (per_fault_o)
    );

    assign sys_lock_o = lock_sync[0];
    assign per_lock_o = lock_sync[1];
    assign rst_req_o  = irq_o & rst_route_i;

endmodule

// File: rtl/clkguard_checker.sv
module clkguard_checker (
    input logic       clk_ref,
    input logic       rst_n,
    input logic [1:0] sel_req_i,
    input logic       err_clr_i,
    input logic       rst_route_i,
    input logic [1:0] sel_o,
    input logic       bkp_active_o,
    input logic       sys_fault_o,
    input logic       irq_o,
    input logic       rst_req_o
);

    // R3: while the guard holds the backup, the backup code is driven
    assert_backup_code_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
        bkp_active_o |-> (sel_o == 2'b00));

    // R3: a latched system PLL fault coincides with the backup being active
    assert_fault_forces_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(sys_fault_o) |-> bkp_active_o);

    // R5: failover can only start from a PLL request
    assert_pll_only_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(bkp_active_o) |-> ($past(sel_req_i) == 2'b01));

    // R6: nothing but a clear ends the failover
    assert_backup_sticky_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (bkp_active_o && !err_clr_i) |=> bkp_active_o);

    // R9: the interrupt is held until a clear
    assert_irq_sticky_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (irq_o && !err_clr_i) |=> irq_o);

    // R10: a reset request never appears unrouted or without an interrupt
    assert_reset_routed_R10: assert property (@(posedge clk_ref) disable iff (!rst_n)
        rst_req_o |-> (irq_o && rst_route_i));

endmodule

bind clkguard_top clkguard_checker u_chk (
    .clk_ref     (clk_ref),
    .rst_n       (rst_n),
    .sel_req_i   (sel_req_i),
    .err_clr_i   (err_clr_i),
    .rst_route_i (rst_route_i),
    .sel_o       (sel_o),
    .bkp_active_o(bkp_active_o),
    .sys_fault_o (sys_fault_o),
    .irq_o       (irq_o),
    .rst_req_o   (rst_req_o)
);

// File: tb/sim_clkguard_top.sv
`timescale 1ns/1ps
module sim_clkguard_top;

    localparam int CNT_W = 12;
    localparam int SETTLE = 200;   // a bit over three measurement windows

    localparam int S_SEL = 0, S_BKP = 1, S_SYSF = 2, S_PERF = 3, S_SYSL = 4,
                   S_PERL = 5, S_OVER = 6, S_UNDER = 7, S_IRQ = 8, S_RST = 9;

    logic             clk_ref = 1'b0;
    logic             clk_mon = 1'b0;
    logic             rst_n = 1'b0;
    logic             sys_lock = 1'b1;
    logic             per_lock = 1'b1;
    logic [1:0]       sel_req = 2'b01;
    logic [CNT_W-1:0] thr_hi = 12'd140;
    logic [CNT_W-1:0] thr_lo = 12'd100;
    logic             err_clr = 1'b0;
    logic             rst_route = 1'b0;
    logic [1:0]       sel_o;
    logic             bkp_active, sys_fault, per_fault, sys_lock_s, per_lock_s;
    logic             over, under, irq, rst_req;

    real mon_half = 5.0;
    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    typedef struct {
        string tag;
        int    sig;
        int    exp;
    } exp_item_t;

    exp_item_t sb_q[$];
    event chk_ev;
    event done_ev;

    always #10 clk_ref = ~clk_ref;
    always #(mon_half) clk_mon = ~clk_mon;

    clkguard_top u0 (
        .clk_ref     (clk_ref),
        .rst_n       (rst_n),
        .clk_mon     (clk_mon),
        .sys_lock_i  (sys_lock),
        .per_lock_i  (per_lock),
        .sel_req_i   (sel_req),
        .thr_hi_i    (thr_hi),
        .thr_lo_i    (thr_lo),
        .err_clr_i   (err_clr),
        .rst_route_i (rst_route),
        .sel_o       (sel_o),
        .bkp_active_o(bkp_active),
        .sys_fault_o (sys_fault),
        .per_fault_o (per_fault),
        .sys_lock_o  (sys_lock_s),
        .per_lock_o  (per_lock_s),
        .over_o      (over),
        .under_o     (under),
        .irq_o       (irq),
        .rst_req_o   (rst_req)
    );

    function automatic int get_sig(int id);
        case (id)
            S_SEL:   return int'(sel_o);
            S_BKP:   return int'(bkp_active);
            S_SYSF:  return int'(sys_fault);
            S_PERF:  return int'(per_fault);
            S_SYSL:  return int'(sys_lock_s);
            S_PERL:  return int'(per_lock_s);
            S_OVER:  return int'(over);
            S_UNDER: return int'(under);
            S_IRQ:   return int'(irq);
            default: return int'(rst_req);
        endcase
    endfunction

    // monitor: pops expectations and compares them at the next falling edge
    initial begin
        forever begin
            @(chk_ev);
            @(negedge clk_ref);
            while (sb_q.size() > 0) begin
                exp_item_t it;
                int act;
                it = sb_q.pop_front();
                act = get_sig(it.sig);
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s (signal %0d): actual %0d expected %0d",
                             it.tag, it.sig, act, it.exp);
                end
            end
            -> done_ev;
        end
    end

    task automatic expect_val(string tag, int sig, int exp);
        exp_item_t it;
        it.tag = tag;
        it.sig = sig;
        it.exp = exp;
        sb_q.push_back(it);
    endtask

    task automatic run_checks();
        -> chk_ev;
        @(done_ev);
    endtask

    task automatic wait_ref(int n);
        repeat (n) @(posedge clk_ref);
    endtask

    task automatic pulse_clear();
        @(negedge clk_ref);
        err_clr = 1'b1;
        @(negedge clk_ref);
        err_clr = 1'b0;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        wait_ref(150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        wait_ref(5);
        @(negedge clk_ref);
        rst_n = 1'b1;

        // R1: state right after reset
        expect_val("R1 sel", S_SEL, 1);
        expect_val("R1 bkp", S_BKP, 0);
        expect_val("R1 sysf", S_SYSF, 0);
        expect_val("R1 perf", S_PERF, 0);
        expect_val("R1 over", S_OVER, 0);
        expect_val("R1 under", S_UNDER, 0);
        expect_val("R1 irq", S_IRQ, 0);
        expect_val("R1 rst", S_RST, 0);
        run_checks();

        // R8: nominal 100 MHz stays in range
        wait_ref(SETTLE);
        expect_val("R8 inrange over", S_OVER, 0);
        expect_val("R8 inrange under", S_UNDER, 0);
        expect_val("R8 inrange irq", S_IRQ, 0);
        run_checks();

        // R2: every code passes through while healthy
        for (int c = 0; c < 4; c++) begin
            @(negedge clk_ref);
            sel_req = 2'(c);
            expect_val("R2 follow", S_SEL, c);
            run_checks();
        end

        // R5 and R11: lock loss with a non-PLL code
        @(negedge clk_ref);
        sel_req = 2'b10;
        sys_lock = 1'b0;
        wait_ref(4);
        expect_val("R5 sel", S_SEL, 2);
        expect_val("R5 bkp", S_BKP, 0);
        expect_val("R5 sysf", S_SYSF, 0);
        expect_val("R11 sys status low", S_SYSL, 0);
        expect_val("R11 per status high", S_PERL, 1);
        run_checks();
        @(negedge clk_ref);
        sys_lock = 1'b1;
        wait_ref(4);
        expect_val("R11 sys status back", S_SYSL, 1);
        run_checks();

        // R3: system PLL lock loss with code 01, exact latency
        @(negedge clk_ref);
        sel_req = 2'b01;
        wait_ref(3);
        @(negedge clk_ref);
        sys_lock = 1'b0;
        wait_ref(2);
        expect_val("R3 not yet", S_SEL, 1);
        run_checks();
        @(posedge clk_ref);
        expect_val("R3 sel", S_SEL, 0);
        expect_val("R3 bkp", S_BKP, 1);
        expect_val("R3 sysf", S_SYSF, 1);
        expect_val("R3 perf", S_PERF, 0);
        run_checks();

        // R6: sticky against returning lock, new code and a clear without locks
        @(negedge clk_ref);
        sys_lock = 1'b1;
        wait_ref(6);
        expect_val("R6 relock holds", S_SEL, 0);
        run_checks();
        @(negedge clk_ref);
        sel_req = 2'b11;
        per_lock = 1'b0;
        wait_ref(4);
        expect_val("R6 code ignored", S_SEL, 0);
        run_checks();
        pulse_clear();
        wait_ref(2);
        expect_val("R6 clear no lock bkp", S_BKP, 1);
        expect_val("R6 clear no lock sel", S_SEL, 0);
        expect_val("R6 clear drops sysf", S_SYSF, 0);
        run_checks();
        @(negedge clk_ref);
        per_lock = 1'b1;
        wait_ref(4);
        pulse_clear();
        wait_ref(1);
        expect_val("R6 release bkp", S_BKP, 0);
        expect_val("R6 release sel", S_SEL, 3);
        run_checks();

        // R4: peripheral PLL lock loss
        @(negedge clk_ref);
        sel_req = 2'b01;
        wait_ref(3);
        @(negedge clk_ref);
        per_lock = 1'b0;
        wait_ref(4);
        expect_val("R4 sel", S_SEL, 0);
        expect_val("R4 bkp", S_BKP, 1);
        expect_val("R4 perf", S_PERF, 1);
        expect_val("R4 sysf", S_SYSF, 0);
        run_checks();
        @(negedge clk_ref);
        per_lock = 1'b1;
        wait_ref(4);
        pulse_clear();
        wait_ref(1);
        expect_val("R4 release sel", S_SEL, 1);
        expect_val("R4 release perf", S_PERF, 0);
        run_checks();

        // R7, R9, R10: over-frequency routed to reset
        @(negedge clk_ref);
        rst_route = 1'b1;
        mon_half = 4.0;
        wait_ref(SETTLE);
        expect_val("R7 over", S_OVER, 1);
        expect_val("R7 under", S_UNDER, 0);
        expect_val("R9 irq", S_IRQ, 1);
        expect_val("R10 routed", S_RST, 1);
        expect_val("R7 sel untouched", S_SEL, 1);
        run_checks();
        mon_half = 5.0;
        wait_ref(SETTLE);
        expect_val("R9 over sticky", S_OVER, 1);
        expect_val("R9 irq sticky", S_IRQ, 1);
        run_checks();
        pulse_clear();
        wait_ref(2);
        expect_val("R9 cleared over", S_OVER, 0);
        expect_val("R9 cleared irq", S_IRQ, 0);
        expect_val("R10 cleared rst", S_RST, 0);
        run_checks();

        // R8, R10: under-frequency, not routed
        @(negedge clk_ref);
        rst_route = 1'b0;
        mon_half = 8.0;
        wait_ref(SETTLE);
        expect_val("R8 under", S_UNDER, 1);
        expect_val("R8 no over", S_OVER, 0);
        expect_val("R9 irq under", S_IRQ, 1);
        expect_val("R10 unrouted", S_RST, 0);
        run_checks();
        mon_half = 5.0;
        wait_ref(SETTLE);
        pulse_clear();
        wait_ref(2);
        expect_val("R8 cleared", S_UNDER, 0);
        run_checks();

        // overlap: lock loss and over-frequency together, one clear releases both
        @(negedge clk_ref);
        mon_half = 4.0;
        sys_lock = 1'b0;
        wait_ref(SETTLE);
        expect_val("R3 overlap bkp", S_BKP, 1);
        expect_val("R3 overlap sysf", S_SYSF, 1);
        expect_val("R7 overlap over", S_OVER, 1);
        expect_val("R9 overlap irq", S_IRQ, 1);
        run_checks();
        @(negedge clk_ref);
        mon_half = 5.0;
        sys_lock = 1'b1;
        wait_ref(SETTLE);
        pulse_clear();
        wait_ref(2);
        expect_val("R6 overlap sel", S_SEL, 1);
        expect_val("R6 overlap bkp", S_BKP, 0);
        expect_val("R9 overlap irq cleared", S_IRQ, 0);
        expect_val("R9 overlap over cleared", S_OVER, 0);
        run_checks();

        finished = 1'b1;
        report();
        $finish;
    end

endmodule